// File: doc/BRIEF.md
# Button-Adjusted PWM Contrast Generator

This block drives a display bias voltage using a pulse-width modulated signal. The period is fixed and the duty cycle is adjustable. An external RC filter turns the waveform into a DC level. That filter is not part of the block. A prescaler divides the system clock into ticks. A tick counter counts up over a period of `PERIOD` ticks, and the output is set and cleared against a compare value. With the default settings a tick is 0.5 us at 50 MHz, so the period is 20 us.

Two active-low push buttons trim the compare value by one tick per press. One button raises it and the other lowers it. The value is held between fixed bounds that are not symmetric about the reset value. Both button inputs are assumed to be debounced already. Each one passes through a two-flop synchroniser and a falling-edge detector. A run input freezes the waveform generator and discards button presses while it is low.

Top module: `contrast_pwm`

## Requirements
- R1: One PWM period spans exactly `PERIOD` ticks (40) of `TICK_DIV` clocks each (25), which is 1000 clock cycles with the defaults.
- R2: After reset the compare value is 20 and `pwmOut` is 0. The first period that follows reset has a high time of 20 ticks.
- R3: A press of the raise button adds one to the compare value only if the value is below 34. The value therefore never exceeds 34.
- R4: A press of the lower button subtracts one from the compare value only if the value is 7 or more. The value therefore never falls below 6.
- R5: Set/reset output: `pwmOut` goes low when the tick counter wraps to 0 and goes high when the counter reaches the compare value. The high time per period is therefore (`PERIOD` minus compare) ticks.
- R6: The tick counter counts up from 0 to `PERIOD`-1 and then wraps to 0.
- R7: While `runEn` is low, the prescaler and tick counter hold, `pwmOut` holds its level, and button presses are discarded. A stall of N cycles lengthens the current period by exactly N cycles.
- R8: A press is a high-to-low transition of a button input after two synchroniser flops. Holding a button low counts as one press.
- R9: A changed compare value takes effect only at the next period wrap. The period in which the press occurs keeps its old high time.
- R10: If raise and lower presses are detected in the same cycle, the compare value does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | High to run; low stalls the waveform and discards presses |
| btnUpN | input | 1 | Raise button, active low |
| btnDownN | input | 1 | Lower button, active low |
| pwmOut | output | 1 | PWM waveform for the bias filter |

## Verification
Two pairs of functions can land on the same clock edge. In the first pair, a raise press and a lower press can reach the step logic together. The bench provokes this by pulling both buttons low on the same cycle, and it judges the outcome by whether the following full period keeps its old high time. In the second pair, a compare update and a running period overlap. The bench presses just after a falling edge of the output, then checks that the current pulse keeps its old width and that only the pulse after the next wrap shows the new value.

// File: rtl/contrast_pwm_pkg.sv
`timescale 1ns/1ps
package contrast_pwm_pkg;

  // strobes passed from the control side to the waveform datapath
  typedef struct packed {
    logic tick;      // one prescaled time step
    logic stepUp;    // accepted raise press
    logic stepDown;  // accepted lower press
  } pwm_strobe_t;

  localparam int unsigned NUM_BTN = 2;
  localparam int unsigned BTN_UP  = 0;
  localparam int unsigned BTN_DN  = 1;

endpackage

// File: rtl/contrast_pwm_ctrl.sv
`timescale 1ns/1ps
module contrast_pwm_ctrl
  import contrast_pwm_pkg::*;
#(
  parameter int unsigned TICK_DIV = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        btnUpN,
  input  logic        btnDownN,
  output pwm_strobe_t strobes
);

  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [NUM_BTN-1:0] rawN;
  logic [NUM_BTN-1:0] syncA;
  logic [NUM_BTN-1:0] syncB;
  logic [NUM_BTN-1:0] lastB;
  logic [NUM_BTN-1:0] fallSeen;
  logic [DIV_W-1:0]   divCnt;
  logic               tickNow;

  assign rawN[BTN_UP] = btnUpN;
  assign rawN[BTN_DN] = btnDownN;

  // per-button synchroniser and falling-edge detector
  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[b] <= 1'b1;
        syncB[b] <= 1'b1;
        lastB[b] <= 1'b1;
      end else begin
        syncA[b] <= rawN[b];
        syncB[b] <= syncA[b];
        lastB[b] <= syncB[b];
      end
    end
    assign fallSeen[b] = lastB[b] & ~syncB[b];
  end

  // tick prescaler
  if (TICK_DIV > 1) begin : g_div
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        divCnt <= '0;
      end else if (runEn) begin
        divCnt <= tickNow ? '0 : divCnt + 1'b1;
      end
    end
    assign tickNow = runEn && (divCnt == DIV_W'(TICK_DIV - 1));
  end else begin : g_nodiv
    assign divCnt  = '0;
    assign tickNow = runEn;
  end

  always_comb begin
    strobes.tick     = tickNow;
    strobes.stepUp   = runEn & fallSeen[BTN_UP] & ~fallSeen[BTN_DN];
    strobes.stepDown = runEn & fallSeen[BTN_DN] & ~fallSeen[BTN_UP];
  end

  AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.stepUp && strobes.stepDown)); // R10

  AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (strobes == '0)); // R7

  AST_STEP_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepUp |-> ($past(syncB[BTN_UP]) && !syncB[BTN_UP])); // R8

endmodule

// File: rtl/contrast_pwm_dp.sv
`timescale 1ns/1ps
module contrast_pwm_dp
  import contrast_pwm_pkg::*;
#(
  parameter int unsigned PERIOD    = 40,
  parameter int unsigned RESET_CMP = 20,
  parameter int unsigned LIMIT_HI  = 34,
  parameter int unsigned LIMIT_LO  = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  pwm_strobe_t strobes,
  output logic        pwmOut
);

  localparam int unsigned CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] CMP_RST  = CNT_W'(RESET_CMP);
  localparam logic [CNT_W-1:0] CMP_HI   = CNT_W'(LIMIT_HI);
  localparam logic [CNT_W-1:0] CMP_LO   = CNT_W'(LIMIT_LO);

  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] shadowCmp;
  logic [CNT_W-1:0] activeCmp;
  logic [CNT_W-1:0] nextCnt;
  logic             atWrap;

  assign atWrap  = (periodCnt == LAST_CNT);
  assign nextCnt = periodCnt + 1'b1;

  // shadow compare with saturating single steps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCmp <= CMP_RST;
    end else if (strobes.stepUp && (shadowCmp < CMP_HI)) begin
      shadowCmp <= shadowCmp + 1'b1;
    end else if (strobes.stepDown && (shadowCmp > CMP_LO)) begin
      shadowCmp <= shadowCmp - 1'b1;
    end
  end

  // up counter, compare reload at wrap, set/reset output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      activeCmp <= CMP_RST;
      pwmOut    <= 1'b0;
    end else if (strobes.tick) begin
      if (atWrap) begin
        periodCnt <= '0;
        activeCmp <= shadowCmp;
        pwmOut    <= 1'b0;
      end else begin
        periodCnt <= nextCnt;
        if (nextCnt == activeCmp) begin
          pwmOut <= 1'b1;
        end
      end
    end
  end

  AST_CMP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (shadowCmp <= CMP_HI) && (shadowCmp >= CMP_LO)); // R3

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (shadowCmp != $past(shadowCmp)) |->
      ((shadowCmp == $past(shadowCmp) + 1'b1) || (shadowCmp == $past(shadowCmp) - 1'b1))); // R4

  AST_RELOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (activeCmp != $past(activeCmp)) |-> ($past(periodCnt) == LAST_CNT)); // R9

  AST_FALL_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwmOut) |-> (periodCnt == '0)); // R5

  AST_RISE_AT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> (periodCnt == activeCmp)); // R5

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    periodCnt <= LAST_CNT); // R6

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tick |=> ($stable(periodCnt) && $stable(pwmOut))); // R7

endmodule

// File: rtl/contrast_pwm.sv
`timescale 1ns/1ps
module contrast_pwm
  import contrast_pwm_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 25,
  parameter int unsigned PERIOD    = 40,
  parameter int unsigned RESET_CMP = 20,
  parameter int unsigned LIMIT_HI  = 34,
  parameter int unsigned LIMIT_LO  = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic btnUpN,
  input  logic btnDownN,
  output logic pwmOut
);

  pwm_strobe_t strobes;

  contrast_pwm_ctrl #(
    .TICK_DIV (TICK_DIV)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .btnUpN   (btnUpN),
    .btnDownN (btnDownN),
    .strobes  (strobes)
  );

  contrast_pwm_dp #(
    .PERIOD    (PERIOD),
    .RESET_CMP (RESET_CMP),
    .LIMIT_HI  (LIMIT_HI),
    .LIMIT_LO  (LIMIT_LO)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pwmOut  (pwmOut)
  );

endmodule

// File: tb/contrast_pwm_test.sv
`timescale 1ns/1ps
module contrast_pwm_test;

  localparam int TD     = 25;
  localparam int PER    = 40;
  localparam int CMP0   = 20;
  localparam int HI_LIM = 34;
  localparam int LO_LIM = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic btnUpN = 1'b1;
  logic btnDownN = 1'b1;
  logic pwmOut;

  int errors = 0;
  int checks = 0;
  int modelCmp = CMP0;
  bit done = 1'b0;

  int    expHigh[$];
  string expTag[$];

  always #10 clk = ~clk;

  contrast_pwm uut (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .btnUpN   (btnUpN),
    .btnDownN (btnDownN),
    .pwmOut   (pwmOut)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int highCycles(input int cmp);
    return (PER - cmp) * TD;
  endfunction

  // monitor: measures each high pulse and the spacing of falling edges
  initial begin
    logic prevOut = 1'b0;
    int   highCnt = 0;
    int   sinceFall = 0;
    bit   seenFall = 1'b0;
    forever begin
      @(negedge clk);
      sinceFall++;
      if (pwmOut) highCnt++;
      if (prevOut && !pwmOut) begin
        if (expHigh.size() > 0) begin
          int    e;
          string t;
          e = expHigh.pop_front();
          t = expTag.pop_front();
          checkEq(t, highCnt, e);
          if (seenFall) checkEq("R1 R6 period length", sinceFall, PER * TD);
        end
        highCnt   = 0;
        sinceFall = 0;
        seenFall  = 1'b1;
      end
      prevOut = pwmOut;
    end
  end

  task automatic waitFall();
    logic p;
    p = pwmOut;
    forever begin
      @(negedge clk);
      if (p && !pwmOut) break;
      p = pwmOut;
    end
  endtask

  task automatic pushExp(input int cmp, input string tag);
    expHigh.push_back(highCycles(cmp));
    expTag.push_back(tag);
  endtask

  // kind: 0 raise, 1 lower, 2 both together
  task automatic adjust(input int kind, input int n, input int holdLen, input string tag);
    waitFall();
    @(negedge clk);
    pushExp(modelCmp, "R9 old width kept in press period");
    for (int i = 0; i < n; i++) begin
      if (kind != 1) btnUpN = 1'b0;
      if (kind != 0) btnDownN = 1'b0;
      repeat (holdLen) @(negedge clk);
      btnUpN = 1'b1;
      btnDownN = 1'b1;
      repeat (3) @(negedge clk);
      if (kind == 0 && modelCmp < HI_LIM) modelCmp++;
      if (kind == 1 && modelCmp >= LO_LIM + 1) modelCmp--;
    end
    waitFall();
    waitFall();
    @(negedge clk);
    pushExp(modelCmp, tag);
    waitFall();
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R2 output low in reset", int'(pwmOut), 0);
    rstN = 1'b1;
    runEn = 1'b1;
    pushExp(CMP0, "R2 first pulse at reset compare");
    @(negedge clk);
    checkEq("R2 output low after reset", int'(pwmOut), 0);
    waitFall();
    @(negedge clk);

    adjust(0, 3, 3, "R3 raise by three");
    adjust(0, 1, 500, "R8 long hold counts once");
    adjust(0, 15, 3, "R3 raise saturates at 34");
    adjust(0, 1, 3, "R3 no raise at 34");
    adjust(1, 40, 3, "R4 lower saturates at 6");
    adjust(1, 1, 3, "R4 no lower at 6");
    adjust(0, 1, 3, "R3 raise from 6 to 7");
    adjust(1, 1, 3, "R4 lower from 7 to 6");
    adjust(0, 10, 3, "R3 raise to 16");
    adjust(2, 2, 3, "R10 simultaneous presses ignored");

    // R7: stall mid low phase with presses while stopped
    begin
      int k = 0;
      int moved = 0;
      logic p;
      waitFall();
      p = pwmOut;
      forever begin
        @(negedge clk);
        k++;
        if (k >= 101 && k <= 2100 && pwmOut !== 1'b0) moved++;
        if (p && !pwmOut) break;
        p = pwmOut;
        if (k == 100) runEn = 1'b0;
        if (k == 300) btnUpN = 1'b0;
        if (k == 306) btnUpN = 1'b1;
        if (k == 400) btnDownN = 1'b0;
        if (k == 406) btnDownN = 1'b1;
        if (k == 2100) runEn = 1'b1;
        if (k > 10000) break;
      end
      checkEq("R7 output held while stopped", moved, 0);
      checkEq("R7 period stretched by stall", k, PER * TD + 2000);
      @(negedge clk);
      pushExp(modelCmp, "R7 presses while stopped ignored");
      waitFall();
      @(negedge clk);
    end

    checkEq("R6 scoreboard drained", expHigh.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule